// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the datapath of a 32-bit load/store processor that runs each instruction over several clock cycles. An external control state machine drives it with strobes and select lines. It reports back only the opcode and function field of the instruction it holds, and a zero flag from its ALU. One word-addressed memory holds both instructions and data. Fetch and data access use that memory in different cycles.

Several internal holding registers keep values from one step to the next: the instruction register, the memory data register, the two operand registers and the ALU output register. Because of them, a single ALU does all the arithmetic. That includes the program counter increment and the branch target sum, so the block has no separate adders. The sign-extended immediate is not stored. It is formed combinationally from the held instruction whenever it is needed. Instruction fields sit at fixed positions: opcode [31:26], first source [25:21], second source [20:16], destination [15:11], immediate [15:0], jump index [25:0], function [5:0].

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high reset clears the program counter to 0 and clears every holding register, so the first fetch after reset reads memory word 0.
- R2: The instruction register loads the memory read word only in a cycle with `ir_we` high, and otherwise keeps its value. `opcode` shows bits [31:26] of the held instruction and `funct` shows bits [5:0].
- R3: The program counter loads the selected next value only when `pc_en` is high. With `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_ctl`=010 (add) and `pc_src`=00 (live ALU result), it advances by 4.
- R4: The memory address is the program counter when `addr_sel`=0 and the ALU output register when `addr_sel`=1. The word index is taken from byte address bits [7:2]. With `mem_we` high, the operand register B is written to the addressed word at the clock edge.
- R5: Operand registers A and B capture the registers named by instruction bits [25:21] and [20:16] every cycle. A register-file write goes to bits [20:16] when `rf_dst_sel`=0 and to bits [15:11] when it is 1. The write data is the ALU output register when `rf_data_sel`=0 and the memory data register (captured every cycle) when it is 1.
- R6: Register 0 always reads as zero, and any write to it has no effect.
- R7: `alu_ctl` selects the ALU operation: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). The ALU output register captures the ALU result every cycle. `alu_a_sel`=1 selects A and `alu_b_sel`=00 selects B.
- R8: `zero` is high exactly when the current ALU result is all zeros.
- R9: `alu_b_sel`=10 selects the sign-extended immediate and 11 selects it shifted left by two. With `pc_src`=01 the program counter loads the ALU output register, so a branch target of PC+4 plus the shifted offset can be computed in one cycle and taken in the next.
- R10: With `pc_src`=10 the program counter loads the jump target: its own upper 4 bits, then instruction bits [25:0], then two zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_en | input | 1 | Program counter load enable |
| ir_we | input | 1 | Instruction register load enable |
| addr_sel | input | 1 | Memory address select: 0 PC, 1 ALU output register |
| mem_we | input | 1 | Memory write strobe (writes B) |
| rf_we | input | 1 | Register file write strobe |
| rf_dst_sel | input | 1 | Write register select: 0 bits [20:16], 1 bits [15:11] |
| rf_data_sel | input | 1 | Write data select: 0 ALU output register, 1 memory data register |
| alu_a_sel | input | 1 | ALU first operand: 0 PC, 1 A |
| alu_b_sel | input | 2 | ALU second operand: B, 4, immediate, immediate x4 |
| alu_ctl | input | 3 | ALU operation code |
| pc_src | input | 2 | Next PC: 00 ALU result, 01 ALU output register, 10 jump target |
| opcode | output | 6 | Bits [31:26] of the held instruction |
| funct | output | 6 | Bits [5:0] of the held instruction |
| zero | output | 1 | ALU result is zero |

## Verification
The bench drives the strobe sequences that an external controller would issue for load, store, register-register, branch and jump steps. Register and memory contents are observed only through the `zero` flag and the fetched fields. Random operand pairs, with random registers for every operation, show that arithmetic, logic, the operand and write-back selects, and the store and reload path all agree with a bench model. Directed cases cover the corners: equal operands, signed compare across the sign boundary, and AND results of zero. Further directed cases cover branches taken and not taken, a jump, held enables, register 0 and a mid-run reset. Decoy words are placed at the addresses a faulty next-PC would reach, so a wrong address shows up as a wrong opcode.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN    = 32;
    localparam int IMM_W   = 16;
    localparam int INDEX_W = 26;
    localparam int OP_W    = 6;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG    = 2'b00,
        SRCB_FOUR   = 2'b01,
        SRCB_IMM    = 2'b10,
        SRCB_IMM_X4 = 2'b11
    } srcb_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'b00,
        PCS_ALUOUT = 2'b01,
        PCS_JUMP   = 2'b10
    } pcsrc_e;

    typedef struct packed {
        logic [OP_W-1:0] opcode;
        logic [4:0]      rs;
        logic [4:0]      rt;
        logic [4:0]      rd;
        logic [4:0]      shamt;
        logic [OP_W-1:0] funct;
    } instr_t;

    typedef struct packed {
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
    } operand_pair_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc,
                                                    input logic [INDEX_W-1:0] index);
        return {pc[XLEN-1:INDEX_W+2], index, 2'b00};
    endfunction

endpackage

// File: rtl/mc_unified_mem.sv
module mc_unified_mem #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            words[idx] <= wdata;
        end
    end

    assign rdata = words[idx];

    AST_MEM_STORE: assert property (@(posedge clk) disable iff (rst) we |=> words[$past(idx)] == $past(wdata)); // R4

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr1,
    output logic [W-1:0]  rdata1,
    input  logic [AW-1:0] raddr2,
    output logic [W-1:0]  rdata2
);

    logic [W-1:0] regs [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
    assign rdata2 = (raddr2 == '0) ? '0 : regs[raddr2];

    AST_RF_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst) (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata)); // R5
    AST_RF_ZERO_READ: assert property (@(posedge clk) disable iff (rst) (we && waddr == '0 && raddr1 == '0) |=> (raddr1 != '0) || (rdata1 == '0)); // R6

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    logic [W-1:0] diff;

    assign diff = a - b;

    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    parameter int REG_COUNT = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pc_en,
    input  logic       ir_we,
    input  logic       addr_sel,
    input  logic       mem_we,
    input  logic       rf_we,
    input  logic       rf_dst_sel,
    input  logic       rf_data_sel,
    input  logic       alu_a_sel,
    input  logic [1:0] alu_b_sel,
    input  logic [2:0] alu_ctl,
    input  logic [1:0] pc_src,
    output logic [5:0] opcode,
    output logic [5:0] funct,
    output logic       zero
);

    localparam int MEM_AW = $clog2(MEM_WORDS);
    localparam int RA_W   = $clog2(REG_COUNT);

    // architectural and holding state
    logic [XLEN-1:0] pc_q;
    instr_t          ir_q;
    logic [XLEN-1:0] mdr_q;
    operand_pair_t   ops_q;
    logic [XLEN-1:0] aluout_q;

    // combinational nets
    logic [MEM_AW-1:0] mem_idx;
    logic [XLEN-1:0]   mem_rdata;
    logic [XLEN-1:0]   rf_rd1;
    logic [XLEN-1:0]   rf_rd2;
    logic [RA_W-1:0]   rf_waddr;
    logic [XLEN-1:0]   rf_wdata;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   src_a;
    logic [XLEN-1:0]   src_b;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   pc_next;

    srcb_e   b_sel;
    pcsrc_e  next_sel;
    alu_op_e op_sel;

    assign b_sel    = srcb_e'(alu_b_sel);
    assign next_sel = pcsrc_e'(pc_src);
    assign op_sel   = alu_op_e'(alu_ctl);

    // shared memory address select
    assign mem_idx = addr_sel ? aluout_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

    mc_unified_mem #(
        .WORDS (MEM_WORDS),
        .W     (XLEN)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .idx   (mem_idx),
        .wdata (ops_q.b),
        .rdata (mem_rdata)
    );

    // register file write-back selects
    assign rf_waddr = rf_dst_sel ? ir_q.rd[RA_W-1:0] : ir_q.rt[RA_W-1:0];
    assign rf_wdata = rf_data_sel ? mdr_q : aluout_q;

    mc_regfile #(
        .DEPTH (REG_COUNT),
        .W     (XLEN)
    ) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .raddr1 (ir_q.rs[RA_W-1:0]),
        .rdata1 (rf_rd1),
        .raddr2 (ir_q.rt[RA_W-1:0]),
        .rdata2 (rf_rd2)
    );

    // operand selection
    assign imm_ext = sext_imm(ir_q[IMM_W-1:0]);
    assign src_a   = alu_a_sel ? ops_q.a : pc_q;

    always_comb begin
        case (b_sel)
            SRCB_REG:    src_b = ops_q.b;
            SRCB_FOUR:   src_b = XLEN'(4);
            SRCB_IMM:    src_b = imm_ext;
            SRCB_IMM_X4: src_b = {imm_ext[XLEN-3:0], 2'b00};
            default:     src_b = ops_q.b;
        endcase
    end

    mc_alu #(
        .W (XLEN)
    ) u_alu (
        .a    (src_a),
        .b    (src_b),
        .op   (op_sel),
        .y    (alu_y),
        .zero (zero)
    );

    // next program counter
    always_comb begin
        case (next_sel)
            PCS_ALU:    pc_next = alu_y;
            PCS_ALUOUT: pc_next = aluout_q;
            PCS_JUMP:   pc_next = jump_target(pc_q, ir_q[INDEX_W-1:0]);
            default:    pc_next = alu_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            ir_q     <= '0;
            mdr_q    <= '0;
            ops_q    <= '0;
            aluout_q <= '0;
        end else begin
            if (pc_en) begin
                pc_q <= pc_next;
            end
            if (ir_we) begin
                ir_q <= mem_rdata;
            end
            mdr_q    <= mem_rdata;
            ops_q.a  <= rf_rd1;
            ops_q.b  <= rf_rd2;
            aluout_q <= alu_y;
        end
    end

    assign opcode = ir_q.opcode;
    assign funct  = ir_q.funct;

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst) !pc_en |=> $stable(pc_q)); // R3
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst) !ir_we |=> $stable(ir_q)); // R2
    AST_ALUOUT_TRACK: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> aluout_q == $past(alu_y)); // R7
    AST_JUMP_FORM: assert property (@(posedge clk) disable iff (rst) (pc_en && next_sel == PCS_JUMP) |=> (pc_q[1:0] == 2'b00) && (pc_q[XLEN-1:XLEN-4] == $past(pc_q[XLEN-1:XLEN-4]))); // R10
    AST_MDR_TRACK: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> mdr_q == $past(mem_rdata)); // R5

endmodule

// File: tb/mc_datapath_test.sv
module mc_datapath_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pc_en, ir_we, addr_sel, mem_we, rf_we;
    logic       rf_dst_sel, rf_data_sel, alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [2:0] alu_ctl;
    logic [1:0] pc_src;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic       zero;

    int          checks = 0;
    int          fails  = 0;
    logic [31:0] pc_m   = 32'd0;

    localparam logic [5:0] DECOY = 6'h3f;

    always #10 clk = ~clk;

    mc_datapath uut (
        .clk(clk), .rst(rst), .pc_en(pc_en), .ir_we(ir_we), .addr_sel(addr_sel),
        .mem_we(mem_we), .rf_we(rf_we), .rf_dst_sel(rf_dst_sel), .rf_data_sel(rf_data_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_ctl(alu_ctl), .pc_src(pc_src),
        .opcode(opcode), .funct(funct), .zero(zero)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        pc_en = 0; ir_we = 0; addr_sel = 0; mem_we = 0; rf_we = 0;
        rf_dst_sel = 0; rf_data_sel = 0; alu_a_sel = 0;
        alu_b_sel = 2'b00; alu_ctl = 3'b010; pc_src = 2'b00;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic put_mem(input logic [31:0] byte_addr, input logic [31:0] v);
        uut.u_mem.words[byte_addr[7:2]] = v;
    endtask

    function automatic logic [31:0] mk_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] alu_model(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
        case (op)
            3'b000: return x & y;
            3'b001: return x | y;
            3'b010: return x + y;
            3'b110: return x - y;
            3'b111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    // fetch the word placed at the model PC, advance by 4 through the ALU
    task automatic fetch_raw(input logic [31:0] w, input string req);
        put_mem(pc_m, w);
        ir_we = 1; addr_sel = 0; alu_a_sel = 0; alu_b_sel = 2'b01;
        alu_ctl = 3'b010; pc_src = 2'b00; pc_en = 1;
        tick();
        pc_m += 4;
        check_eq(req, {26'd0, opcode}, {26'd0, w[31:26]});
        check_eq(req, {26'd0, funct}, {26'd0, w[5:0]});
    endtask

    task automatic jump_to(input logic [25:0] index);
        fetch_raw({6'h02, index}, "R2 jump fetch");
        pc_src = 2'b10; pc_en = 1;
        tick();
        pc_m = {pc_m[31:28], index, 2'b00};
    endtask

    task automatic fetch(input logic [31:0] w, input string req);
        if (pc_m >= 32'd128) begin
            put_mem(32'd0, {DECOY, 26'd0});
            jump_to(26'd0);
        end
        fetch_raw(w, req);
    endtask

    task automatic load_reg(input int k, input int word);
        fetch(mk_i(6'h23, 0, k, word * 4), "R2 load fetch");
        tick();
        alu_a_sel = 1; alu_b_sel = 2'b10; alu_ctl = 3'b010;
        tick();
        addr_sel = 1;
        tick();
        rf_we = 1; rf_dst_sel = 0; rf_data_sel = 1;
        tick();
    endtask

    task automatic store_reg(input int k, input int word);
        fetch(mk_i(6'h2b, 0, k, word * 4), "R2 store fetch");
        tick();
        alu_a_sel = 1; alu_b_sel = 2'b10; alu_ctl = 3'b010;
        tick();
        addr_sel = 1; mem_we = 1;
        tick();
    endtask

    task automatic rtype(input int rs, input int rt, input int rd, input logic [2:0] op);
        fetch(mk_r(rs, rt, rd, {3'b100, op}), "R2 rtype fetch");
        tick();
        alu_a_sel = 1; alu_b_sel = 2'b00; alu_ctl = op;
        tick();
        rf_we = 1; rf_dst_sel = 1; rf_data_sel = 0;
        tick();
    endtask

    task automatic compare_regs(input int rs, input int rt, input logic exp_eq, input string req);
        fetch(mk_r(rs, rt, 0, 6'h2a), "R2 compare fetch");
        tick();
        alu_a_sel = 1; alu_b_sel = 2'b00; alu_ctl = 3'b110;
        #1;
        check_eq(req, {31'd0, zero}, {31'd0, exp_eq});
        tick();
    endtask

    task automatic compare_imm(input int rs, input int imm, input logic exp_eq, input string req);
        fetch(mk_i(6'h08, rs, 0, imm), "R2 imm fetch");
        tick();
        alu_a_sel = 1; alu_b_sel = 2'b10; alu_ctl = 3'b110;
        #1;
        check_eq(req, {31'd0, zero}, {31'd0, exp_eq});
        tick();
    endtask

    task automatic branch(input int rs, input int rt, input int off, input logic taken);
        logic [31:0] target;
        if (pc_m >= 32'd96) begin
            put_mem(32'd0, {DECOY, 26'd0});
            jump_to(26'd0);
        end
        fetch_raw(mk_i(6'h04, rs, rt, off), "R2 branch fetch");
        target = pc_m + 32'(off * 4);
        put_mem(pc_m, {DECOY, 26'd1});
        put_mem(target, {DECOY, 26'd2});
        alu_a_sel = 0; alu_b_sel = 2'b11; alu_ctl = 3'b010;
        tick();
        alu_a_sel = 1; alu_b_sel = 2'b00; alu_ctl = 3'b110;
        pc_src = 2'b01; pc_en = taken;
        #1;
        check_eq("R8 branch compare zero", {31'd0, zero}, {31'd0, taken});
        tick();
        if (taken) pc_m = target;
        fetch_raw(mk_i(6'h0d, 0, 0, 16'h1234), "R9 branch next fetch");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] x, y, e;
        logic [2:0]  op;
        int          ra, rb, re, rd;
        logic [2:0]  ops [5];
        ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
        void'($urandom(32'd2024));
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: first fetch after reset comes from word 0
        fetch_raw(mk_r(1, 2, 3, 6'h21), "R1 reset fetch");

        // R6: register 0 reads zero, even after writes aimed at it
        put_mem(32'd200, 32'h0000_0055);
        load_reg(0, 50);
        compare_imm(0, 0, 1'b1, "R6 zero after load");
        load_reg(5, 50);
        compare_imm(5, 16'h0055, 1'b1, "R5 load via rt and MDR");
        rtype(5, 5, 0, 3'b010);
        compare_imm(0, 0, 1'b1, "R6 zero after rtype");
        compare_imm(5, 16'h0056, 1'b0, "R8 zero low on mismatch");

        // R2: instruction register holds without its strobe
        fetch(mk_r(3, 4, 5, 6'h15), "R2 fetch");
        put_mem(pc_m - 4, {6'h11, 20'd0, 6'h0b});
        addr_sel = 0; pc_src = 2'b00; alu_b_sel = 2'b01;
        tick();
        check_eq("R2 ir hold opcode", {26'd0, opcode}, 32'd0);
        check_eq("R2 ir hold funct", {26'd0, funct}, 32'h15);

        // R3: PC holds without its enable
        put_mem(pc_m + 4, {DECOY, 26'd3});
        alu_a_sel = 0; alu_b_sel = 2'b01; alu_ctl = 3'b010; pc_src = 2'b00; pc_en = 0;
        tick();
        fetch(mk_i(6'h0f, 0, 0, 7), "R3 pc hold then fetch");

        // R9: branch taken and not taken
        put_mem(32'd204, 32'hffff_fff0);
        put_mem(32'd208, 32'hffff_fff0);
        put_mem(32'd212, 32'h0000_0010);
        load_reg(6, 51);
        load_reg(7, 52);
        load_reg(8, 53);
        branch(6, 7, 3, 1'b1);
        branch(6, 8, 2, 1'b0);

        // R10: jump lands on the target word
        put_mem(32'd40, {DECOY, 26'd4});
        jump_to(26'd12);
        fetch_raw(mk_i(6'h0a, 0, 0, 1), "R10 jump target fetch");

        // R7 R8 R4 R5: random and directed operand pairs
        for (int i = 0; i < 30; i++) begin
            x  = $urandom();
            y  = $urandom();
            op = ops[$urandom_range(0, 4)];
            if (i == 0) begin y = x; op = 3'b110; end
            if (i == 1) begin x = 32'h8000_0003; y = 32'h0000_0002; op = 3'b111; end
            if (i == 2) begin x = 32'h0000_0002; y = 32'hffff_fffe; op = 3'b111; end
            if (i == 3) begin x = 32'hf0f0_0000; y = 32'h0f0f_ffff; op = 3'b000; end
            if (i == 4) begin x = 32'h7fff_ffff; y = 32'h0000_0001; op = 3'b010; end
            e  = alu_model(op, x, y);
            ra = 1 + $urandom_range(0, 6);
            rb = 8 + $urandom_range(0, 7);
            re = 16 + $urandom_range(0, 7);
            rd = 24 + $urandom_range(0, 6);
            put_mem(32'd192, x);
            put_mem(32'd196, y);
            put_mem(32'd200, e);
            put_mem(32'd204, ~e);
            load_reg(ra, 48);
            load_reg(rb, 49);
            load_reg(re, 50);
            rtype(ra, rb, rd, op);
            compare_regs(rd, re, 1'b1, "R7 alu result");
            compare_regs(ra, rb, (x == y), "R8 zero on operands");
            store_reg(rd, 51);
            load_reg(31, 51);
            compare_regs(31, re, 1'b1, "R4 store then reload");
        end

        // R1: mid-run reset returns fetch to word 0
        put_mem(pc_m, {DECOY, 26'd5});
        rst = 1;
        tick();
        rst = 0;
        pc_m = 32'd0;
        fetch_raw(mk_i(6'h09, 0, 0, 3), "R1 fetch after second reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule